// File: doc/BRIEF.md
# Synchronous Serial Port (Master/Slave)

A byte-wide, full-duplex, three-wire synchronous serial port. One clock line, a master-to-slave data line and a slave-to-master data line carry one byte per transfer, shifted out and in at the same time. A control register bit picks the role. As master, the port produces the serial clock from the system clock divided by a programmable ratio and starts a transfer when software writes the data register. As slave, the port follows an external serial clock while its active-low select input is held low.

Software sees three registers behind a small select/strobe interface: control, status and data. Reading the data register returns the last byte received. The status register holds a completion flag and a write-collision flag. Clock polarity, clock phase and bit order are set in the control register, so all four common clock modes work in either order.

Top module: `spi_port`

## Requirements
- R1: After reset, control, status and data all read 0x00, the port is in slave mode, `sck_o` is 0, and `sck_oe`, `mosi_oe` and `miso_oe` are 0 while `ss_n` is high.
- R2: Register select 0 is control: bit 0 master, bit 1 LSB-first, bit 2 clock polarity, bit 3 clock phase, bits 5:4 rate. Bits 7:6 read 0. Select 1 is status: bit 0 done, bit 1 write collision. Select 2 is data.
- R3: In master mode, a data write while idle starts a transfer of 16 serial clock edges. The done flag sets exactly 16*H system clocks after the write edge, where H is 2, 8, 32 or 64 for rate 0, 1, 2 or 3 (division by 4, 16, 64 or 128).
- R4: With LSB-first at 1, bit 0 is shifted first. With it at 0, bit 7 is shifted first.
- R5: The serial clock idles at the polarity bit. With phase 0, data is sampled on the leading edge (the one leaving idle). With phase 1, it is sampled on the trailing edge.
- R6: A transfer is full duplex. The byte received on the input data line is returned by a data register read.
- R7: The done flag sets when the eighth bit completes. It clears only when a data access (read or write) follows a status read made while a flag was set. A data read alone leaves it set.
- R8: A data write during a transfer, including in the transfer's final cycle, sets the collision flag and is ignored. The running transfer's bits are unchanged, and no new transfer starts.
- R9: In slave mode with `ss_n` low, the port drives `miso_o` (`miso_oe` = 1), shifts with `sck_i` and receives from `mosi_i`. With `ss_n` high, it releases `miso_oe` and ignores `sck_i`. In master mode, `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives flag clearing) |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line, slave receive |
| mosi_o | output | 1 | Master-out line, master transmit |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line, master receive |
| miso_o | output | 1 | Master-in line, slave transmit |
| miso_oe | output | 1 | Master-in output enable |
| ss_n | input | 1 | Active-low slave select |

## Verification
The completion of a transfer and a software write to the data register can land on the same clock edge. The bench starts a master transfer at the fastest rate and times a second data write so that it is sampled on exactly the edge where the eighth bit finishes. Because the port is still busy on that edge, the bench expects status to show both done and collision. It also expects the serial clock to stay at its idle level afterwards, which shows that the late write neither started a new transfer nor disturbed the ending one.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    typedef struct packed {
        logic [1:0] rate;
        logic       cpha;
        logic       cpol;
        logic       lsb_first;
        logic       master;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        logic  done;
        logic  wcol;
        logic  armed;
    } port_regs_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[0] <= RST_VAL;
                else        st_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[i] <= RST_VAL;
                else        st_q[i] <= st_q[i-1];
            end
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q, last;

    // half serial period in system clocks: 2, 8, 32, 64
    always_comb begin
        case (rate)
            2'd0:    last = CNT_W'(1);
            2'd1:    last = CNT_W'(7);
            2'd2:    last = CNT_W'(31);
            default: last = CNT_W'(63);
        endcase
        tick  = run && (cnt_q == last);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          start,
    input  logic          master,
    input  logic          lsb_first,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          tick,
    input  logic          sck_in,
    input  logic          sin,
    input  logic          slave_en,
    output logic          sout,
    output logic          sck_out,
    output logic          busy,
    output logic          done_pulse,
    output logic [DW-1:0] rx_buf
);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
        logic [DW-1:0] rxbuf;
        logic [CW-1:0] cnt;
        logic          phase;
        logic          first;
        logic          started;
        logic          sck_prev;
    } eng_t;

    eng_t e_d, e_q;
    logic edge_ev, lead, sample;
    logic [DW-1:0] rx_nx, tx_nx;

    always_comb begin
        e_d        = e_q;
        done_pulse = 1'b0;
        e_d.sck_prev = sck_in;
        if (master) begin
            edge_ev = tick;
            lead    = !e_q.phase;
        end else begin
            edge_ev = slave_en && (sck_in != e_q.sck_prev);
            lead    = (sck_in != cpol);
        end
        sample = cpha ? !lead : lead;
        rx_nx  = lsb_first ? {sin, e_q.rx[DW-1:1]} : {e_q.rx[DW-2:0], sin};
        tx_nx  = lsb_first ? {1'b0, e_q.tx[DW-1:1]} : {e_q.tx[DW-2:0], 1'b0};

        if (master && tick) e_d.phase = !e_q.phase;

        if (edge_ev) begin
            e_d.started = 1'b1;
            if (sample) begin
                e_d.rx = rx_nx;
            end else begin
                if (!cpha || !e_q.first) e_d.tx = tx_nx;
                e_d.first = 1'b0;
            end
            if (!lead) begin
                if (e_q.cnt == CW'(DW-1)) begin
                    e_d.cnt     = '0;
                    e_d.started = 1'b0;
                    e_d.first   = 1'b1;
                    e_d.rxbuf   = sample ? rx_nx : e_q.rx;
                    done_pulse  = 1'b1;
                end else begin
                    e_d.cnt = e_q.cnt + 1'b1;
                end
            end
        end

        if (!master && !slave_en) begin
            e_d.cnt     = '0;
            e_d.first   = 1'b1;
            e_d.started = 1'b0;
        end
        if (load) begin
            e_d.tx    = load_data;
            e_d.first = 1'b1;
        end
        if (start) e_d.started = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q       <= '0;
            e_q.first <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign sout    = lsb_first ? e_q.tx[0] : e_q.tx[DW-1];
    assign sck_out = cpol ^ e_q.phase;
    assign busy    = e_q.started;
    assign rx_buf  = e_q.rxbuf;
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n
);
    localparam int CTRL_W = $bits(ctrl_t);

    port_regs_t r_d, r_q;
    logic [2:0] pins_s;
    logic ss_s, sck_s, mosi_s;
    logic tick, busy, done_pulse, sout, slave_en, sck_int;
    logic data_wr, data_acc, accept, collide;
    logic [DW-1:0] rx_buf;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_n, sck_i, mosi_i}), .q(pins_s)
    );
    assign {ss_s, sck_s, mosi_s} = pins_s;
    assign slave_en = !r_q.ctrl.master && !ss_s;

    spi_rate_div #(.CNT_W(6)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy && r_q.ctrl.master),
        .rate(r_q.ctrl.rate), .tick(tick)
    );

    assign data_wr  = reg_wr && (reg_sel == SEL_DATA);
    assign data_acc = (reg_wr || reg_rd) && (reg_sel == SEL_DATA);
    assign accept   = data_wr && !busy;
    assign collide  = data_wr && busy;

    spi_shift_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .load_data(reg_wdata), .start(accept && r_q.ctrl.master),
        .master(r_q.ctrl.master), .lsb_first(r_q.ctrl.lsb_first),
        .cpol(r_q.ctrl.cpol), .cpha(r_q.ctrl.cpha), .tick(tick),
        .sck_in(sck_s), .sin(r_q.ctrl.master ? miso_i : mosi_s),
        .slave_en(slave_en), .sout(sout), .sck_out(sck_int), .busy(busy),
        .done_pulse(done_pulse), .rx_buf(rx_buf)
    );

    always_comb begin
        r_d = r_q;
        if (reg_wr && reg_sel == SEL_CTRL) r_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (r_q.armed && data_acc) begin
            r_d.done  = 1'b0;
            r_d.wcol  = 1'b0;
            r_d.armed = 1'b0;
        end
        if (reg_rd && reg_sel == SEL_STAT && (r_q.done || r_q.wcol)) r_d.armed = 1'b1;
        if (done_pulse) r_d.done = 1'b1;
        if (collide)    r_d.wcol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = DW'(r_q.ctrl);
            SEL_STAT: reg_rdata = DW'({r_q.wcol, r_q.done});
            SEL_DATA: reg_rdata = rx_buf;
            default:  reg_rdata = '0;
        endcase
    end

    assign sck_o   = sck_int;
    assign sck_oe  = r_q.ctrl.master;
    assign mosi_o  = sout;
    assign mosi_oe = r_q.ctrl.master;
    assign miso_o  = sout;
    assign miso_oe = slave_en;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic cpol,
    input logic busy,
    input logic done,
    input logic wcol,
    input logic data_acc,
    input logic data_wr,
    input logic sck_o,
    input logic sck_oe,
    input logic mosi_oe,
    input logic miso_oe
);
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done && !data_acc |=> done);
    a_r8_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && busy |=> wcol);
    a_r9_master_drivers: assert property (@(posedge clk) disable iff (!rst_n)
        master |-> sck_oe && mosi_oe && !miso_oe);
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o == cpol);
endmodule

bind spi_port spi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(r_q.ctrl.master), .cpol(r_q.ctrl.cpol),
    .busy(busy), .done(r_q.done), .wcol(r_q.wcol), .data_acc(data_acc),
    .data_wr(data_wr), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_oe(mosi_oe),
    .miso_oe(miso_oe)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_sel = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic sck_i = 0, sck_o, sck_oe, mosi_i = 0, mosi_o, mosi_oe;
    logic miso_i, miso_o, miso_oe, ss_n = 1;

    int checks = 0, fails = 0;
    int edges = 0;
    logic [7:0] cap = 0;
    logic cur_cpol = 0, cur_cpha = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign miso_i = ~mosi_o;

    spi_port dut (.*);

    // {ctrl, tx byte, expected wire order (first bit in bit 7)}
    localparam logic [23:0] VEC [8] = '{
        {8'h01, 8'hA5, 8'hA5}, {8'h03, 8'h1E, 8'h78},
        {8'h05, 8'h3C, 8'h3C}, {8'h09, 8'hC1, 8'hC1},
        {8'h0F, 8'h06, 8'h60}, {8'h11, 8'h5B, 8'h5B},
        {8'h2B, 8'h01, 8'h80}, {8'h37, 8'hF0, 8'h0F}
    };

    always @(sck_o) begin
        edges++;
        if (sck_oe && ((sck_o != cur_cpol) == !cur_cpha)) cap = {cap[6:0], mosi_o};
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1;
        @(posedge clk); #1 reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk); reg_sel = s; reg_rd = 1; #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] d);
        reg_sel = s; #1 d = reg_rdata;
    endtask

    task automatic set_ctrl(input logic [7:0] c);
        wr(2'd0, c); cur_cpol = c[2]; cur_cpha = c[3];
        edges = 0; cap = 0;
    endtask

    function automatic int half_of(input logic [1:0] r);
        case (r) 2'd0: return 2; 2'd1: return 8; 2'd2: return 32; default: return 64; endcase
    endfunction

    task automatic wait_done(output int n);
        logic [7:0] s;
        n = 0; s = 0;
        while (!s[0] && n < 20000) begin
            @(posedge clk); #1 n++; peek(2'd1, s);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        peek(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 0);
        peek(2'd1, v); check(v == 8'h00, "R1 status", v, 0);
        peek(2'd2, v); check(v == 8'h00, "R1 data", v, 0);
        check({sck_o, sck_oe, mosi_oe, miso_oe} == 4'b0, "R1 pins", {sck_o, sck_oe, mosi_oe, miso_oe}, 0);
        rst_n = 1;
        repeat (2) @(posedge clk);

        // R2 control readback, upper bits read zero
        wr(2'd0, 8'hFF); peek(2'd0, v); check(v == 8'h3F, "R2 ctrl readback", v, 8'h3F);

        // vector table: R3 timing, R4 order, R5 modes, R6 duplex, R7 flags
        for (int i = 0; i < 8; i++) begin
            logic [7:0] c, tx, ex;
            {c, tx, ex} = VEC[i];
            set_ctrl(c);
            check(sck_o == c[2], "R5 idle level", sck_o, c[2]);
            wr(2'd2, tx);
            wait_done(n);
            check(n == 16 * half_of(c[5:4]), "R3 transfer time", n, 16 * half_of(c[5:4]));
            check(edges == 16, "R3 edge count", edges, 16);
            check(cap == ex, "R4/R5 wire bits", cap, ex);
            rd(2'd1, v); check(v == 8'h01, "R7 done set", v, 1);
            rd(2'd2, v); check(v == ~tx, "R6 received byte", v, ~tx);
            peek(2'd1, v); check(v == 8'h00, "R7 flag cleared", v, 0);
        end

        // R7 data read without a prior status read leaves done set
        set_ctrl(8'h01);
        wr(2'd2, 8'h44); wait_done(n);
        rd(2'd2, v); peek(2'd1, v); check(v == 8'h01, "R7 done kept", v, 1);
        rd(2'd1, v); rd(2'd2, v); peek(2'd1, v); check(v == 8'h00, "R7 done cleared", v, 0);

        // R8 collision in mid-transfer is ignored
        set_ctrl(8'h01);
        wr(2'd2, 8'h96); repeat (5) @(posedge clk);
        wr(2'd2, 8'h00);
        peek(2'd1, v); check(v == 8'h02, "R8 wcol set", v, 2);
        wait_done(n);
        check(cap == 8'h96, "R8 transfer intact", cap, 8'h96);
        rd(2'd1, v); check(v == 8'h03, "R8 both flags", v, 3);
        rd(2'd2, v); check(v == 8'h69, "R8 rx intact", v, 8'h69);

        // R8 write in the final cycle: done and collision together
        set_ctrl(8'h01);
        wr(2'd2, 8'h33);
        repeat (31) @(posedge clk);
        wr(2'd2, 8'hCC);
        peek(2'd1, v); check(v == 8'h03, "R8 same-edge flags", v, 3);
        edges = 0; repeat (40) @(posedge clk); #1;
        check(edges == 0 && sck_o == 0, "R8 no restart", edges, 0);
        rd(2'd1, v); rd(2'd2, v);

        // R9 slave mode, mode 0, MSB first
        set_ctrl(8'h00);
        wr(2'd2, 8'hC6);
        ss_n = 0; repeat (6) @(posedge clk); #1;
        check(miso_oe == 1 && sck_oe == 0 && mosi_oe == 0, "R9 slave drive", miso_oe, 1);
        cap = 0;
        for (int b = 7; b >= 0; b--) begin
            mosi_i = 8'h4D >> b;
            repeat (8) @(posedge clk); #1 cap = {cap[6:0], miso_o};
            sck_i = 1; repeat (8) @(posedge clk);
            sck_i = 0; repeat (8) @(posedge clk);
        end
        check(cap == 8'hC6, "R9 slave transmit", cap, 8'hC6);
        rd(2'd1, v); check(v == 8'h01, "R9 slave done", v, 1);
        rd(2'd2, v); check(v == 8'h4D, "R9 slave receive", v, 8'h4D);
        ss_n = 1; repeat (6) @(posedge clk); #1;
        check(miso_oe == 0, "R9 released", miso_oe, 0);
        for (int k = 0; k < 16; k++) begin
            sck_i = ~sck_i; repeat (8) @(posedge clk);
        end
        #1 peek(2'd1, v); check(v == 8'h00, "R9 sck ignored", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule